// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Forwarding

This block sits between a write-through cache and the next memory level. The processor hands it stores and moves on at once. The block keeps them in a small circular queue and writes them out to memory in the background, oldest first, one per handshake. A store whose address is already held in a waiting entry is folded into that entry rather than taking a new slot. The match is found in two steps: the address bits that pick the lower-level set are compared first, and the remaining bits only matter when those agree. Each entry keeps a byte-enable mask, so partial-word stores that are merged together stay exact.

A read miss from the cache goes ahead of the queued writes. The miss address is compared with every waiting entry, and the block presents the buffered bytes for that address on the forwarding outputs. If those bytes cover the whole word, the miss is answered there and no memory read is issued. Otherwise the block sends the read to memory ahead of the pending writes. The cache then lays the forwarded bytes over the returned data, so a read never sees memory data that is older than a buffered store.

Back-pressure rules: a store is taken on a cycle where `st_valid` and `st_ready` are both high. A miss is consumed on a cycle where `miss_valid` and `miss_ready` are both high. The memory port transfers on a cycle where `mem_valid` and `mem_ready` are both high. A write offered to memory and not yet accepted remains on the port unchanged, unless a read miss takes the port first. The queue depth must be a power of two, at least 2. Addresses are word addresses.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the queue is empty: `mem_valid` is 0, `st_ready` is 1 and `fwd_hit` is 0.
- R2: Accepted stores that do not merge are written to memory in arrival order. Each write shows `mem_we`=1 with the entry's address, data and byte mask, and is removed from the queue when `mem_valid` and `mem_ready` are both high. With the queue empty and no miss pending, `mem_valid` is 0.
- R3: A store whose full address equals that of a waiting entry (other than one currently offered to memory) merges into it. The bytes whose `st_strb` bit is set are overwritten, the entry's mask becomes the OR of both masks, and no new entry is used.
- R4: A store that agrees with a waiting entry only in the set field (bits SET_LSB to SET_LSB+SET_W-1), or in no field, takes a new entry.
- R5: When all DEPTH entries are in use, `st_ready` is 0 for a store that cannot merge and 1 for one that can.
- R6: When `miss_valid` is 1 and the forwarded bytes do not cover the whole word, the memory port carries a read (`mem_we`=0, `mem_addr`=`miss_addr`) ahead of any waiting write, and `miss_ready` equals `mem_ready`.
- R7: `fwd_hit` is 1 when any waiting entry has address `miss_addr`. For each byte b, `fwd_strb[b]` is 1 when a matching entry holds that byte, and `fwd_data` byte b is taken from the youngest such entry. Bytes that are not held read as zero.
- R8: When `miss_valid` is 1 and `fwd_strb` is all ones, `miss_ready` is 1, no read is issued, and the port may drain a write in that cycle.
- R9: A write that is offered and not accepted is, in the next cycle, either still offered with the same address and data, or displaced by a read.
- R10: The entry currently offered to memory is never a merge target. A store to its address takes a new entry, and forwarding then combines both entries with the younger bytes on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_strb | input | DW/8 | Store byte enables |
| miss_valid | input | 1 | Read miss offered |
| miss_ready | output | 1 | Read miss consumed |
| miss_addr | input | AW | Read miss word address |
| fwd_hit | output | 1 | Some waiting entry matches the miss address |
| fwd_data | output | DW | Buffered bytes for the miss address |
| fwd_strb | output | DW/8 | Which bytes of fwd_data are buffered |
| mem_valid | output | 1 | Memory request offered |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | DW | Write data |
| mem_wstrb | output | DW/8 | Write byte enables |

## Verification
The bench targets a store aimed at the head entry while that entry sits stalled on the memory port. A design that merges there would either lose bytes or change data already offered. It also builds two entries for one address and checks that forwarding overlays the younger bytes; a design that takes only the oldest match would return stale data and expose the read-after-write hazard. Set-field aliases (same set, different tag) must take separate entries, because a design that stopped at the pre-compare would corrupt another address. A full queue must still accept a mergeable store, and a fully covered miss must not issue a spurious memory read.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mem_op_e;
endpackage

// File: rtl/sfb_addr_cmp.sv
module sfb_addr_cmp #(
  parameter int AW      = 16,
  parameter int DEPTH   = 4,
  parameter int SET_LSB = 0,
  parameter int SET_W   = 6
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0]         ent_vld,
  input  logic [AW-1:0]            probe,
  output logic [DEPTH-1:0]         full_hit
);
  localparam logic [AW-1:0] SET_MASK = AW'(((1 << SET_W) - 1) << SET_LSB);

  logic [DEPTH-1:0] set_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    // coarse step: only the set-select field
    assign set_hit[g]  = ent_vld[g] && (((ent_addr[g] ^ probe) & SET_MASK) == '0);
    // fine step: remaining bits, qualified by the coarse result
    assign full_hit[g] = set_hit[g] && (((ent_addr[g] ^ probe) & ~SET_MASK) == '0);
  end
endmodule

// File: rtl/sfb_fwd_merge.sv
module sfb_fwd_merge #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int NB   = DW / 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         hit,
  input  logic [PW-1:0]            head,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [DEPTH-1:0][NB-1:0] ent_strb,
  output logic [DW-1:0]            fwd_data,
  output logic [NB-1:0]            fwd_strb
);
  logic [PW-1:0] idx;

  // walk oldest to youngest so younger bytes land last
  always_comb begin
    fwd_data = '0;
    fwd_strb = '0;
    idx      = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (hit[idx]) begin
        for (int b = 0; b < NB; b++) begin
          if (ent_strb[idx][b]) begin
            fwd_data[8*b +: 8] = ent_data[idx][8*b +: 8];
            fwd_strb[b]        = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int DEPTH   = 4,
  parameter int SET_LSB = 0,
  parameter int SET_W   = 6,
  localparam int NB     = DW / 8,
  localparam int PW     = $clog2(DEPTH),
  localparam int CW     = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [NB-1:0] st_strb,
  input  logic          miss_valid,
  output logic          miss_ready,
  input  logic [AW-1:0] miss_addr,
  output logic          fwd_hit,
  output logic [DW-1:0] fwd_data,
  output logic [NB-1:0] fwd_strb,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [NB-1:0] mem_wstrb
);
  import sfb_pkg::*;

  logic [DEPTH-1:0][AW-1:0] e_addr;
  logic [DEPTH-1:0][DW-1:0] e_data;
  logic [DEPTH-1:0][NB-1:0] e_strb;
  logic [DEPTH-1:0]         e_vld;
  logic [PW-1:0]            head, tail;
  logic [CW-1:0]            count;

  logic [DEPTH-1:0] st_hit, miss_hit, merge_cand, head_oh;
  logic             full_cover, rd_go, wr_offer, drain;
  logic             merge_ok, push, mrg;
  logic [PW-1:0]    merge_idx, scan_idx;

  sfb_addr_cmp #(.AW(AW), .DEPTH(DEPTH), .SET_LSB(SET_LSB), .SET_W(SET_W)) i_st_cmp (
    .ent_addr(e_addr), .ent_vld(e_vld), .probe(st_addr), .full_hit(st_hit)
  );

  sfb_addr_cmp #(.AW(AW), .DEPTH(DEPTH), .SET_LSB(SET_LSB), .SET_W(SET_W)) i_miss_cmp (
    .ent_addr(e_addr), .ent_vld(e_vld), .probe(miss_addr), .full_hit(miss_hit)
  );

  sfb_fwd_merge #(.DW(DW), .DEPTH(DEPTH)) i_fwd (
    .hit(miss_hit), .head(head), .ent_data(e_data), .ent_strb(e_strb),
    .fwd_data(fwd_data), .fwd_strb(fwd_strb)
  );

  // memory port arbitration: an uncovered miss wins over draining
  assign fwd_hit    = |miss_hit;
  assign full_cover = &fwd_strb;
  assign rd_go      = miss_valid && !full_cover;
  assign wr_offer   = (count != '0) && !rd_go;
  assign drain      = wr_offer && mem_ready;

  assign mem_valid  = rd_go || wr_offer;
  assign mem_we     = rd_go ? OP_READ : OP_WRITE;
  assign mem_addr   = rd_go ? miss_addr : e_addr[head];
  assign mem_wdata  = e_data[head];
  assign mem_wstrb  = e_strb[head];
  assign miss_ready = full_cover || mem_ready;

  // merge target: youngest full match, head excluded while offered
  assign head_oh    = DEPTH'(1) << head;
  assign merge_cand = st_hit & ~(head_oh & {DEPTH{wr_offer}});

  always_comb begin
    merge_ok  = 1'b0;
    merge_idx = head;
    scan_idx  = head;
    for (int k = 0; k < DEPTH; k++) begin
      scan_idx = head + PW'(k);
      if (merge_cand[scan_idx]) begin
        merge_ok  = 1'b1;
        merge_idx = scan_idx;
      end
    end
  end

  assign st_ready = merge_ok || (count != CW'(DEPTH));
  assign push     = st_valid && st_ready && !merge_ok;
  assign mrg      = st_valid && merge_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        e_vld[tail] <= 1'b1;
        tail        <= tail + PW'(1);
      end
      if (drain) begin
        e_vld[head] <= 1'b0;
        head        <= head + PW'(1);
      end
      count <= count + CW'(push) - CW'(drain);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[tail] <= st_addr;
      e_data[tail] <= st_data;
      e_strb[tail] <= st_strb;
    end else if (mrg) begin
      for (int b = 0; b < NB; b++) begin
        if (st_strb[b]) e_data[merge_idx][8*b +: 8] <= st_data[8*b +: 8];
      end
      e_strb[merge_idx] <= e_strb[merge_idx] | st_strb;
    end
  end
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int NB   = DW / 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          miss_valid,
  input logic          miss_ready,
  input logic [AW-1:0] miss_addr,
  input logic          fwd_hit,
  input logic [NB-1:0] fwd_strb,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5

  AST_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !miss_valid) |-> !mem_valid); // R2

  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !(&fwd_strb)) |-> (mem_valid && !mem_we && mem_addr == miss_addr)); // R6

  AST_LOCAL_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && (&fwd_strb)) |-> (miss_ready && !(mem_valid && !mem_we))); // R8

  AST_FWD_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (count != '0)); // R7

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !mem_ready) |=>
      (mem_valid && (!mem_we || ($stable(mem_addr) && $stable(mem_wdata))))); // R9
endmodule

bind store_fwd_buffer sfb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_sfb_checker (
  .clk(clk), .rst_n(rst_n), .count(count),
  .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
  .fwd_hit(fwd_hit), .fwd_strb(fwd_strb),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/test_store_fwd_buffer.sv
module test_store_fwd_buffer;
  localparam int AW = 16, DW = 32, DEPTH = 4, NB = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, miss_valid = 0, mem_ready = 0;
  logic [AW-1:0] st_addr = '0, miss_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [NB-1:0] st_strb = '0;
  logic st_ready, miss_ready, fwd_hit, mem_valid, mem_we;
  logic [DW-1:0] fwd_data, mem_wdata;
  logic [NB-1:0] fwd_strb, mem_wstrb;
  logic [AW-1:0] mem_addr;

  store_fwd_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_store_fwd_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_strb(st_strb),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .fwd_hit(fwd_hit), .fwd_data(fwd_data), .fwd_strb(fwd_strb),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb)
  );

  always #2 clk = ~clk;

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic [NB-1:0] s; } ent_t;
  ent_t q[$];
  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit run = 0, done = 0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  // reference model: evaluated at the falling edge, state advanced for the next rising edge
  logic [DW-1:0] e_fd;
  logic [NB-1:0] e_fs;
  logic e_fh, e_cover, e_rd, e_wr, e_sr;
  int mj;
  always @(negedge clk) begin
    if (rst_n && run && !done) begin
      e_fd = '0; e_fs = '0; e_fh = 0;
      foreach (q[j]) if (q[j].a == miss_addr) begin
        e_fh = 1;
        for (int b = 0; b < NB; b++) if (q[j].s[b]) begin
          e_fd[8*b +: 8] = q[j].d[8*b +: 8];
          e_fs[b] = 1;
        end
      end
      e_cover = &e_fs;
      e_rd = miss_valid && !e_cover;
      e_wr = !e_rd && q.size() > 0;
      mj = -1;
      foreach (q[j]) if (q[j].a == st_addr && !(j == 0 && e_wr)) mj = j;
      e_sr = (mj >= 0) || q.size() < DEPTH;

      chk("mem_valid", 64'(mem_valid), 64'(e_rd || e_wr));
      if (e_rd) begin
        chk("read mem_we", 64'(mem_we), 64'(0));
        chk("read mem_addr", 64'(mem_addr), 64'(miss_addr));
      end
      if (e_wr) begin
        chk("write mem_we", 64'(mem_we), 64'(1));
        chk("write mem_addr", 64'(mem_addr), 64'(q[0].a));
        chk("write mem_wdata", 64'(mem_wdata), 64'(q[0].d));
        chk("write mem_wstrb", 64'(mem_wstrb), 64'(q[0].s));
      end
      chk("st_ready", 64'(st_ready), 64'(e_sr));
      if (miss_valid) chk("miss_ready", 64'(miss_ready), 64'(e_cover || mem_ready));
      chk("fwd_hit", 64'(fwd_hit), 64'(e_fh));
      chk("fwd_strb", 64'(fwd_strb), 64'(e_fs));
      chk("fwd_data", 64'(fwd_data), 64'(e_fd));

      if (st_valid && e_sr) begin
        if (mj >= 0) begin
          for (int b = 0; b < NB; b++) if (st_strb[b]) q[mj].d[8*b +: 8] = st_data[8*b +: 8];
          q[mj].s = q[mj].s | st_strb;
        end else begin
          ent_t e;
          e.a = st_addr; e.d = st_data; e.s = st_strb;
          q.push_back(e);
        end
      end
      if (e_wr && mem_ready) void'(q.pop_front());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] s);
    st_valid = 1; st_addr = a; st_data = d; st_strb = s;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired in phase %s", phase);
    done = 1;
    summary();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; run = 1;
    // R1: reset state
    @(negedge clk);
    chk("R1 mem_valid", 64'(mem_valid), 0);
    chk("R1 st_ready", 64'(st_ready), 1);
    chk("R1 fwd_hit", 64'(fwd_hit), 0);
    cyc();

    phase = "R2";
    put(16'h0010, 32'h1000_0001, 4'hf); cyc();
    put(16'h0020, 32'h2000_0002, 4'hf); cyc();
    put(16'h0030, 32'h3000_0003, 4'h3); cyc();
    st_valid = 0; mem_ready = 1;
    repeat (4) cyc();
    mem_ready = 0;
    @(negedge clk); chk("R2 empty port idle", 64'(mem_valid), 0);
    cyc();

    phase = "R3";
    put(16'h0100, 32'hCAFE_0100, 4'hf); cyc();
    put(16'h0005, 32'h1111_22AA, 4'h3); cyc();
    put(16'h0005, 32'hBBCC_3333, 4'hc); cyc();
    st_valid = 0; miss_valid = 1; miss_addr = 16'h0005;
    @(negedge clk);
    chk("R3 merged data", 64'(fwd_data), 64'(32'hBBCC_22AA));
    chk("R3 merged mask", 64'(fwd_strb), 64'hf);
    chk("R8 covered miss ready", 64'(miss_ready), 1);
    chk("R8 write keeps port", 64'(mem_we), 1);
    cyc(); miss_valid = 0;

    phase = "R4";
    put(16'h0045, 32'h0000_0011, 4'h1); cyc();
    phase = "R5";
    put(16'h0006, 32'h6666_6666, 4'hf); cyc();
    put(16'h0007, 32'h7777_7777, 4'hf);
    @(negedge clk); chk("R5 full blocks new", 64'(st_ready), 0);
    cyc();
    put(16'h0045, 32'h0000_2200, 4'h2);
    @(negedge clk); chk("R5 full accepts merge", 64'(st_ready), 1);
    cyc();
    phase = "R10";
    put(16'h0100, 32'h0000_0000, 4'hf);
    @(negedge clk); chk("R10 head not merge target", 64'(st_ready), 0);
    cyc(); st_valid = 0;

    phase = "R6";
    miss_valid = 1; miss_addr = 16'h0200;
    @(negedge clk);
    chk("R6 read on port", 64'(mem_we), 0);
    chk("R6 read addr", 64'(mem_addr), 64'h0200);
    chk("R6 miss waits", 64'(miss_ready), 0);
    cyc(); mem_ready = 1;
    @(negedge clk); chk("R6 miss taken", 64'(miss_ready), 1);
    cyc(); mem_ready = 0;
    phase = "R7";
    miss_addr = 16'h0045;
    @(negedge clk);
    chk("R7 hit", 64'(fwd_hit), 1);
    chk("R7 partial mask", 64'(fwd_strb), 64'h3);
    chk("R7 partial data", 64'(fwd_data), 64'h2211);
    cyc();
    phase = "R8";
    miss_addr = 16'h0005; mem_ready = 1;
    @(negedge clk);
    chk("R8 ready", 64'(miss_ready), 1);
    chk("R8 drain addr", 64'(mem_addr), 64'h0100);
    cyc(); miss_valid = 0; mem_ready = 0;

    phase = "R10";
    put(16'h0005, 32'h0000_00EE, 4'h1);
    @(negedge clk); chk("R10 new entry", 64'(st_ready), 1);
    cyc(); st_valid = 0; miss_valid = 1; miss_addr = 16'h0005;
    @(negedge clk);
    chk("R10 younger byte", 64'(fwd_data), 64'(32'hBBCC_22EE));
    chk("R10 mask", 64'(fwd_strb), 64'hf);
    cyc(); miss_valid = 0;

    phase = "R9";
    @(negedge clk); chk("R9 held addr", 64'(mem_addr), 64'h0005);
    cyc();
    @(negedge clk); chk("R9 held addr later", 64'(mem_addr), 64'h0005);
    chk("R9 held data", 64'(mem_wdata), 64'(32'hBBCC_22AA));
    cyc();

    phase = "R2/R7 random";
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] pool [4];
      pool[0] = 16'h0005; pool[1] = 16'h0045; pool[2] = 16'h0006; pool[3] = 16'h1005;
      st_valid = ($urandom % 2) == 0;
      st_addr = pool[$urandom % 4];
      st_data = $urandom;
      st_strb = NB'(($urandom % 15) + 1);
      miss_valid = ($urandom % 3) == 0;
      miss_addr = pool[$urandom % 4];
      mem_ready = ($urandom % 2) == 0;
      cyc();
    end
    phase = "R2";
    st_valid = 0; miss_valid = 0; mem_ready = 1;
    repeat (8) cyc();
    @(negedge clk); chk("R2 drained", 64'(mem_valid), 0);
    done = 1;
    summary();
  end
endmodule